// File: doc/BRIEF.md
# Pixel Clock PLL Divider Search Engine

This block works out the divider settings for a pixel-clock PLL that runs from a fixed 14,318,180 Hz reference. A one-cycle `start` pulse hands it a requested output frequency in hertz. Any request outside 3.125 MHz to 220 MHz is refused at once with an error flag. An accepted request is first doubled until it reaches the VCO floor of 100 MHz, and each doubling counts as one step of post-division. The engine then tries every reference divider N from 3 to 257. For each N it takes the feedback divider M as the truncated quotient N × target / reference and scores it against the target.

M has two valid ranges. With the VCO loop divide set to 1, M runs from 3 to 257 and is scored as it is. With the loop divide set to 4, M runs up to 1028, but only its upper bits can be stored, so it is scored with its two low bits cleared. A candidate wins only when its score is strictly lower than the best so far. The winner is then packed into three bytes that can be written straight to the PLL registers. Software starts a search, waits for `done` and copies the three codes.

Top module: `pixpll_search`

## Requirements
- R1: A `start` seen while idle with `target_hz` above 220,000,000 or below 3,125,000 raises `done` together with `err` on the very next clock edge, and no search is run.
- R2: Both range limits are inclusive: 3,125,000 and 220,000,000 are accepted and searched, with `err` low when `done` rises.
- R3: The target is doubled while it is below 100,000,000. Bits 7:4 of `div_code` hold the number of doublings (0x10 per doubling). Bits 1:0 and bit 3 of `div_code` are always zero.
- R4: For each N in 3..257 in rising order, M = floor(N × f / 14,318,180), where f is the scaled target. A candidate replaces the best only when its score is strictly smaller, so on a tie the smallest N is kept.
- R5: When M ≤ 257 the score is |f·N − 14,318,180·M|. When 257 < M ≤ 1028 the score uses M with bits 1:0 cleared. When M > 1028 the candidate is skipped.
- R6: If the winning M is above 257, `m_code` = (M >> 2) − 2 and bit 2 of `div_code` is 0. Otherwise `m_code` = M − 2 and bit 2 of `div_code` is 1. In both cases `n_code` = N − 2. All three are 8-bit values.
- R7: `done` is a single-cycle pulse. `busy` is high from the edge that accepts a request until the edge that raises `done`, and it is low while `done` is high. The codes and `err` hold their values until the next accepted `start`.
- R8: A `start` that arrives while `busy` is high has no effect, whether its target is in range or out of range.
- R9: After reset, `busy`, `done` and `err` are low and all three codes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| target_hz | input | 32 | Requested output frequency in Hz, sampled with `start` |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | The last request was refused |
| m_code | output | 8 | Feedback divider code (M − 2 after any loop-divide shift) |
| n_code | output | 8 | Reference divider code (N − 2) |
| div_code | output | 8 | Post-divide count in bits 7:4, loop-divide-1 select in bit 2 |

## Verification
A wrong internal state does not show up on the ports until `done`. If the residual or M is off by one at any N, the winning pair drifts, and the packed codes no longer match the exact 64-bit search in the bench at the end of a run of about 1,800 cycles. A range fault shows one edge after `start`, as a late or missing `err`. The bench sweeps the full accepted range in steps, together with both limits, the scaling floor and requests made while busy. Loop-divide selection, tie order and the doubling count are therefore all compared against the independent model.

// File: rtl/pixpll_pkg.sv
package pixpll_pkg;
    localparam int TW  = 32;   // frequency / residual width
    localparam int NW  = 9;    // reference divider width
    localparam int MW  = 12;   // feedback divider width before packing
    localparam int KW  = 3;    // division step counter width
    localparam int K_TOP = 5;  // highest quotient bit per division

    typedef enum logic [2:0] {
        S_IDLE, S_SCALE, S_DIV, S_SCORE, S_PACK
    } srch_state_e;

    typedef struct packed {
        srch_state_e       state;
        logic [TW-1:0]     ft;
        logic [7:0]        div;
        logic [NW-1:0]     n;
        logic [MW-1:0]     m;
        logic [TW-1:0]     rem;
        logic [KW-1:0]     k;
        logic [TW-1:0]     best_err;
        logic [MW-1:0]     best_m;
        logic [NW-1:0]     best_n;
        logic              found;
        logic              done;
        logic              err;
        logic [7:0]        m_code;
        logic [7:0]        n_code;
        logic [7:0]        div_code;
    } srch_regs_t;
endpackage

// File: rtl/pixpll_divstep.sv
module pixpll_divstep import pixpll_pkg::*; #(
    parameter int REF_HZ = 14318180
) (
    input  logic [TW-1:0] rem_i,
    input  logic [MW-1:0] m_i,
    input  logic [KW-1:0] k_i,
    output logic [TW-1:0] rem_o,
    output logic [MW-1:0] m_o
);
    // One restoring step: try to remove REF << k from the residual.
    logic [TW:0] sub_v;

    always_comb begin
        sub_v = (TW+1)'(REF_HZ) << k_i;
        if ({1'b0, rem_i} >= sub_v) begin
            rem_o = rem_i - sub_v[TW-1:0];
            m_o   = m_i + (MW'(1) << k_i);
        end else begin
            rem_o = rem_i;
            m_o   = m_i;
        end
    end
endmodule

// File: rtl/pixpll_score.sv
module pixpll_score import pixpll_pkg::*; #(
    parameter int REF_HZ       = 14318180,
    parameter int M_DIRECT_MAX = 257,
    parameter int M_MASK_MAX   = 1028
) (
    input  logic [TW-1:0] rem_i,
    input  logic [MW-1:0] m_i,
    output logic          valid_o,
    output logic [TW-1:0] score_o
);
    // rem_i is f*N - REF*M (already in [0, REF)); clearing M's low bits adds REF*M[1:0].
    logic [TW-1:0] low_pen;

    always_comb begin
        low_pen = TW'(REF_HZ) * TW'(m_i[1:0]);
        valid_o = (m_i <= MW'(M_MASK_MAX));
        score_o = (m_i <= MW'(M_DIRECT_MAX)) ? rem_i : rem_i + low_pen;
    end
endmodule

// File: rtl/pixpll_search.sv
module pixpll_search import pixpll_pkg::*; #(
    parameter int REF_HZ       = 14318180,
    parameter int MIN_HZ       = 3125000,
    parameter int MAX_HZ       = 220000000,
    parameter int FLOOR_HZ     = 100000000,
    parameter int N_FIRST      = 3,
    parameter int N_LAST       = 257,
    parameter int M_DIRECT_MAX = 257,
    parameter int M_MASK_MAX   = 1028
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   target_hz,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [7:0]    m_code,
    output logic [7:0]    n_code,
    output logic [7:0]    div_code
);
    localparam logic [TW-1:0] LO_V    = TW'(MIN_HZ);
    localparam logic [TW-1:0] HI_V    = TW'(MAX_HZ);
    localparam logic [TW-1:0] FLOOR_V = TW'(FLOOR_HZ);
    localparam logic [TW-1:0] REF_V   = TW'(REF_HZ);
    localparam logic [NW-1:0] NF_V    = NW'(N_FIRST);
    localparam logic [NW-1:0] NL_V    = NW'(N_LAST);
    localparam logic [MW-1:0] MD_V    = MW'(M_DIRECT_MAX);

    srch_regs_t st_d, st_q;

    logic [TW-1:0] rem_step;
    logic [MW-1:0] m_step;
    logic          sc_valid;
    logic [TW-1:0] sc_val;
    logic          out_range;
    logic [MW-1:0] m_packed;

    pixpll_divstep #(.REF_HZ(REF_HZ)) i_divstep (
        .rem_i (st_q.rem),
        .m_i   (st_q.m),
        .k_i   (st_q.k),
        .rem_o (rem_step),
        .m_o   (m_step)
    );

    pixpll_score #(
        .REF_HZ      (REF_HZ),
        .M_DIRECT_MAX(M_DIRECT_MAX),
        .M_MASK_MAX  (M_MASK_MAX)
    ) i_score (
        .rem_i   (st_q.rem),
        .m_i     (st_q.m),
        .valid_o (sc_valid),
        .score_o (sc_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        out_range = (target_hz > HI_V) || (target_hz < LO_V);
        m_packed  = (st_q.best_m > MD_V) ? (st_q.best_m >> 2) : st_q.best_m;

        unique case (st_q.state)
            S_IDLE: begin
                if (start) begin
                    if (out_range) begin
                        st_d.done = 1'b1;
                        st_d.err  = 1'b1;
                    end else begin
                        st_d.err   = 1'b0;
                        st_d.ft    = target_hz;
                        st_d.div   = 8'h00;
                        st_d.state = S_SCALE;
                    end
                end
            end
            S_SCALE: begin
                if (st_q.ft < FLOOR_V) begin
                    st_d.ft  = st_q.ft << 1;
                    st_d.div = st_q.div + 8'h10;
                end else begin
                    st_d.n        = NF_V;
                    st_d.m        = '0;
                    st_d.rem      = TW'(N_FIRST) * st_q.ft;
                    st_d.k        = KW'(K_TOP);
                    st_d.best_err = '1;
                    st_d.best_m   = '0;
                    st_d.best_n   = '0;
                    st_d.found    = 1'b0;
                    st_d.state    = S_DIV;
                end
            end
            S_DIV: begin
                st_d.rem = rem_step;
                st_d.m   = m_step;
                if (st_q.k == '0) st_d.state = S_SCORE;
                else              st_d.k     = st_q.k - KW'(1);
            end
            S_SCORE: begin
                if (sc_valid && (sc_val < st_q.best_err)) begin
                    st_d.best_err = sc_val;
                    st_d.best_m   = st_q.m;
                    st_d.best_n   = st_q.n;
                    st_d.found    = 1'b1;
                end
                if (st_q.n == NL_V) begin
                    st_d.state = S_PACK;
                end else begin
                    st_d.n     = st_q.n + NW'(1);
                    st_d.rem   = st_q.rem + st_q.ft;
                    st_d.k     = KW'(K_TOP);
                    st_d.state = S_DIV;
                end
            end
            S_PACK: begin
                st_d.done  = 1'b1;
                st_d.state = S_IDLE;
                if (!st_q.found) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.m_code   = 8'(m_packed - MW'(2));
                    st_d.n_code   = 8'(st_q.best_n - NW'(2));
                    st_d.div_code = st_q.div | ((st_q.best_m > MD_V) ? 8'h00 : 8'h04);
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.state != S_IDLE);
    assign done     = st_q.done;
    assign err      = st_q.err;
    assign m_code   = st_q.m_code;
    assign n_code   = st_q.n_code;
    assign div_code = st_q.div_code;

    AST_REJECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((target_hz > HI_V) || (target_hz < LO_V))) |=> (done && err)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_SCALED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_DIV) |-> (st_q.ft >= FLOOR_V)); // R3
    AST_RESIDUAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_SCORE) |-> (st_q.rem < REF_V)); // R4
    AST_N_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_SCORE) |-> ((st_q.n >= NF_V) && (st_q.n <= NL_V))); // R4
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.state == S_DIV) || (st_q.state == S_SCORE)) |=> $stable(st_q.ft)); // R8
endmodule

// File: tb/test_pixpll_search.sv
`timescale 1ns/1ps
module test_pixpll_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_hz = '0;
    logic        busy, done, err;
    logic [7:0]  m_code, n_code, div_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pixpll_search i_pixpll_search (
        .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
        .busy(busy), .done(done), .err(err),
        .m_code(m_code), .n_code(n_code), .div_code(div_code)
    );

    localparam longint unsigned REF = 14318180;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Exact 64-bit model of the search, written from R1..R6.
    task automatic model(input longint unsigned t, output bit e_err,
                         output logic [7:0] e_m, output logic [7:0] e_n, output logic [7:0] e_d);
        longint unsigned f, best, bm, bn, m, sc, mm;
        int d;
        e_err = 1'b0; e_m = 0; e_n = 0; e_d = 0;
        if (t > 220000000 || t < 3125000) begin
            e_err = 1'b1;
            return;
        end
        f = t; d = 0;
        while (f < 100000000) begin f = f << 1; d += 16; end
        best = 64'hFFFF_FFFF_FFFF_FFFF; bm = 0; bn = 0;
        for (longint unsigned n = 3; n <= 257; n++) begin
            m = (n * f) / REF;
            if (m <= 257) mm = m;
            else if (m <= 1028) mm = m & ~64'd3;
            else continue;
            sc = (n * f >= REF * mm) ? n * f - REF * mm : REF * mm - n * f;
            if (sc < best) begin best = sc; bm = m; bn = n; end
        end
        if (bm > 257) bm = bm >> 2;
        else d = d | 4;
        e_m = 8'(bm - 2);
        e_n = 8'(bn - 2);
        e_d = 8'(d);
    endtask

    task automatic pulse_start(input logic [31:0] t);
        @(negedge clk);
        start = 1'b1; target_hz = t;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Runs one request; optionally fires a second start while busy (R8).
    task automatic run(input logic [31:0] t, input bit poke, input logic [31:0] t2);
        bit e_err; logic [7:0] e_m, e_n, e_d;
        int waited;
        model(t, e_err, e_m, e_n, e_d);
        pulse_start(t);
        if (e_err) begin
            check(done === 1'b1 && err === 1'b1, "R1 reject next edge", {done, err}, 3);
            check(busy === 1'b0, "R1 no search", busy, 0);
        end else begin
            check(busy === 1'b1 && done === 1'b0, "R7 busy after accept", {busy, done}, 2);
            if (poke) begin
                repeat (3) @(negedge clk);
                start = 1'b1; target_hz = t2;
                @(negedge clk);
                start = 1'b0;
                check(done === 1'b0 && busy === 1'b1, "R8 start ignored while busy", {busy, done}, 2);
            end
            waited = 0;
            while (done !== 1'b1 && waited < 5000) begin
                check(busy === 1'b1, "R7 busy until done", busy, 1);
                @(negedge clk);
                waited++;
            end
            check(done === 1'b1, "R7 done reached", done, 1);
            check(busy === 1'b0, "R7 busy low with done", busy, 0);
            check(err === 1'b0, "R2 accepted err low", err, 0);
            check(m_code === e_m, "R4 R5 R6 m_code", m_code, e_m);
            check(n_code === e_n, "R4 R6 n_code", n_code, e_n);
            check(div_code === e_d, "R3 R6 div_code", div_code, e_d);
            check(div_code[1:0] === 2'b00 && div_code[3] === 1'b0, "R3 unused div bits", div_code, e_d);
        end
        @(negedge clk);
        check(done === 1'b0, "R7 single pulse", done, 0);
        if (!e_err) check(m_code === e_m && n_code === e_n, "R7 codes held", m_code, e_m);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R9 reset flags", {busy, done, err}, 0);
        check(m_code === 0 && n_code === 0 && div_code === 0, "R9 reset codes", {m_code, n_code, div_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R9 idle after reset", {busy, done}, 0);

        run(32'd3125000,   1'b0, 0);            // R2 lower limit
        run(32'd3124999,   1'b0, 0);            // R1 just below
        run(32'd220000000, 1'b0, 0);            // R2 upper limit
        run(32'd220000001, 1'b0, 0);            // R1 just above
        run(32'd0,         1'b0, 0);            // R1
        run(32'hFFFF_FFFF, 1'b0, 0);            // R1
        run(32'd100000000, 1'b0, 0);            // R3 no doubling
        run(32'd99999999,  1'b0, 0);            // R3 one doubling
        run(32'd25175000,  1'b1, 32'd5000000);  // R8 in-range poke
        run(32'd65000000,  1'b1, 32'd250000000);// R8 out-of-range poke
        for (int i = 0; i < 38; i++)
            run(32'd3000000 + 32'(i) * 32'd5900000, 1'b0, 0); // R4 R5 R6 sweep
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule